// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Controller

This block is the bus-facing half of a small nonvolatile byte memory built from up to four 256-byte banks. It watches the two-wire clock and data lines, recognises bus START and STOP conditions, checks the device code in the control byte, keeps a word-address pointer, and drives an open-drain pull-down enable for the data line. It serves single-byte writes, page writes of up to one page, current-address reads, random reads and sequential reads that stream through the whole array.

Written bytes leave through a valid/ready port towards a page buffer. A one-cycle commit pulse at STOP tells the array to start its timed write cycle. While the array reports that cycle as busy, the controller acknowledges nothing, so a master can poll with its own address until it sees an acknowledge. Array data comes back through a synchronous read port with one cycle of latency.

Back-pressure rules for the write port: once `wr_valid` rises, `wr_addr` and `wr_data` stay stable until a cycle with `wr_ready` high, and `wr_valid` falls in the next cycle. The buffer must accept each byte within eight SCL periods, which is before the next byte or the STOP that commits the page can arrive.

Top module: `eei2c_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe` low), and `wr_valid`, `commit` and `rd_en` are low.
- R2: The slave acknowledges a control byte only when its bits 7:4 are 1010. For any other code it drives no acknowledge and stays silent until the next START.
- R3: In a write (control bit 0 = 0), the word address byte is acknowledged and loaded into the pointer. Control bits 2:1 become pointer bits 9:8 (B1 as bit 9, B0 as bit 8), and control bit 3 is ignored. With two banks, only bit 1 is used.
- R4: Each data byte in a write is acknowledged and presented on the write port at the current pointer. Only the low four pointer bits then increment, wrapping inside the 16-byte page, so byte 17 of a page write lands where byte 1 went.
- R5: `commit` pulses for one cycle after a STOP that ends a write carrying at least one data byte. A STOP after a read, a STOP after a write with no data byte, or a transfer cut short by START, produces no pulse.
- R6: While `wc_busy` is high, no byte is acknowledged, the control byte included.
- R7: A read (control bit 0 = 1) sends the byte at the pointer and advances the pointer by one. The bank bits of a read control byte are ignored, so a current-address read after accessing address n returns address n+1.
- R8: A write header followed by a repeated START and a read control byte returns the byte at the address the header loaded.
- R9: When the master acknowledges a read byte, the next address follows. The pointer crosses bank boundaries and wraps from the top address to 0.
- R10: After a master NACK the slave keeps SDA released until the next START.
- R11: A START at any bit position aborts the transfer and restarts control-byte reception.
- R12: `sda_oe` changes only in the cycle after a synchronised SCL falling edge, START or STOP, never in the middle of an SCL high phase.
- R13: A byte offered on the write port holds its address and data until the cycle in which `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Filtered bus clock level |
| sda_i | input | 1 | Filtered bus data level |
| sda_oe | output | 1 | 1 pulls the data line low |
| wc_busy | input | 1 | Array write cycle in progress |
| wr_valid | output | 1 | Write byte offered to the page buffer |
| wr_ready | input | 1 | Page buffer accepts the byte |
| wr_addr | output | AW (10) | Array address of the offered byte |
| wr_data | output | 8 | Offered byte |
| commit | output | 1 | One-cycle request to start the write cycle |
| rd_en | output | 1 | Read request to the array |
| rd_addr | output | AW (10) | Read address |
| rd_data | input | 8 | Array data, valid the cycle after `rd_en` |

## Verification
A wrong pointer shows up at the ports as a wrong byte on the very next read. The bench follows the pointer through writes, page wraps, aborted transfers and reads with ignored bank bits, and each read compares every bit against a model memory. A phase error shows up as an acknowledge at the wrong bit, or as a missing acknowledge, on the next ninth clock. A missed or spurious commit appears within one busy window: either the acknowledge-polling loop never sees the slave busy, or the next read returns stale data. SDA changes during SCL high and write-port hold violations are watched on every cycle.

// File: rtl/eei2c_pkg.sv
package eei2c_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    K_CTRL, K_ADDR, K_DATA
  } rxkind_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eei2c_sync.sv
module eei2c_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {STAGES{RST_VAL}};
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/eei2c_cond.sv
module eei2c_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data edges while the clock stays high are bus conditions
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eei2c_slave.sv
module eei2c_slave
  import eei2c_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int PAGE_BYTES  = 16,
  parameter int SYNC_STAGES = 2,
  localparam int BANK_BITS  = $clog2(NUM_BANKS),
  localparam int AW         = 8 + BANK_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          wc_busy,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          commit,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data
);
  localparam int PAGE_BITS = $clog2(PAGE_BYTES);

  // line synchronisers: index 1 = clock, index 0 = data
  logic [1:0] raw, syn;
  assign raw = {scl_i, sda_i};
  for (genvar g = 0; g < 2; g++) begin : g_sync
    eei2c_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw[g]), .q(syn[g])
    );
  end

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  assign scl_s = syn[1];
  assign sda_s = syn[0];

  eei2c_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  phase_t               phase;
  rxkind_t              kind;
  logic [2:0]           cnt;
  logic                 byte_done, rw_q, wmode, wrote, mack, ld_pend;
  logic [7:0]           rx_sh, tx_sh;
  logic [BANK_BITS-1:0] bank_q;
  logic [AW-1:0]        ptr;
  logic                 byte_end, data_take;

  assign byte_end  = scl_fall && (phase == S_RX) && byte_done;
  assign data_take = byte_end && (kind == K_DATA) && !wc_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= S_IDLE;   kind <= K_CTRL;   cnt <= '0;
      byte_done <= 1'b0; rw_q <= 1'b0;     wmode <= 1'b0;
      wrote <= 1'b0;     mack <= 1'b0;     ld_pend <= 1'b0;
      rx_sh <= '0;       tx_sh <= '0;      bank_q <= '0;
      ptr <= '0;         sda_oe <= 1'b0;   wr_valid <= 1'b0;
      wr_addr <= '0;     wr_data <= '0;    commit <= 1'b0;
      rd_en <= 1'b0;     rd_addr <= '0;
    end else begin
      commit  <= 1'b0;
      rd_en   <= 1'b0;
      ld_pend <= rd_en;
      if (ld_pend) tx_sh <= rd_data;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;

      if (start_det) begin
        phase <= S_RX; kind <= K_CTRL; cnt <= '0;
        byte_done <= 1'b0; sda_oe <= 1'b0; wrote <= 1'b0; wmode <= 1'b0;
      end else if (stop_det) begin
        phase <= S_IDLE; sda_oe <= 1'b0;
        if (wmode && wrote) commit <= 1'b1;
        wrote <= 1'b0; wmode <= 1'b0;
      end else begin
        unique case (phase)
          S_RX: begin
            if (scl_rise) begin
              rx_sh <= {rx_sh[6:0], sda_s};
              cnt   <= cnt + 3'd1;
              if (cnt == 3'd7) byte_done <= 1'b1;
            end else if (byte_end) begin
              byte_done <= 1'b0;
              cnt       <= '0;
              if (wc_busy) begin
                phase <= S_SKIP;            // acknowledge polling: stay silent
              end else begin
                unique case (kind)
                  K_CTRL: begin
                    if (rx_sh[7:4] == DEV_CODE) begin
                      sda_oe <= 1'b1; phase <= S_ACK;
                      rw_q   <= rx_sh[0]; wmode <= ~rx_sh[0];
                      bank_q <= rx_sh[BANK_BITS:1];
                      if (rx_sh[0]) begin
                        rd_en <= 1'b1; rd_addr <= ptr; ptr <= ptr + AW'(1);
                      end
                    end else begin
                      phase <= S_SKIP;
                    end
                  end
                  K_ADDR: begin
                    sda_oe <= 1'b1; phase <= S_ACK;
                    ptr    <= {bank_q, rx_sh};
                  end
                  default: begin
                    sda_oe   <= 1'b1; phase <= S_ACK;
                    wr_valid <= 1'b1; wr_addr <= ptr; wr_data <= rx_sh;
                    wrote    <= 1'b1;
                    ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + PAGE_BITS'(1);
                  end
                endcase
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                phase <= S_TX; cnt <= '0; sda_oe <= ~tx_sh[7];
              end else begin
                phase  <= S_RX; sda_oe <= 1'b0;
                kind   <= (kind == K_CTRL) ? K_ADDR : K_DATA;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_oe <= 1'b0; phase <= S_MACK;
              end else begin
                cnt    <= cnt + 3'd1;
                tx_sh  <= {tx_sh[6:0], 1'b0};
                sda_oe <= ~tx_sh[6];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
              if (!sda_s) begin
                rd_en <= 1'b1; rd_addr <= ptr; ptr <= ptr + AW'(1);
              end
            end else if (scl_fall) begin
              if (mack) begin
                phase <= S_TX; cnt <= '0; sda_oe <= ~tx_sh[7];
              end else begin
                phase <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) $rose(rst_n) |-> !sda_oe && !wr_valid && !commit && !rd_en);

  p_bad_code_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end && kind == K_CTRL && rx_sh[7:4] != DEV_CODE |=> phase == S_SKIP && !sda_oe);

  p_page_upper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_take |=> wr_valid && $stable(ptr[AW-1:PAGE_BITS]));

  p_commit_at_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop_det));

  p_busy_no_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end && wc_busy |=> !sda_oe);

  p_skip_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phase == S_SKIP |-> !sda_oe);

  p_start_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> phase == S_RX && kind == K_CTRL && !sda_oe && cnt == 3'd0);

  p_sda_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  p_wr_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready && !data_take |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
endmodule

// File: tb/tb_eei2c_slave.sv
module tb_eei2c_slave;
  localparam int CLK_P    = 10;
  localparam int H        = 8;
  localparam int AW       = 10;
  localparam int MEM_N    = 1024;
  localparam int BUSY_CYC = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wc_busy, wr_valid, wr_ready, commit, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_P/2) clk = ~clk;

  eei2c_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .wc_busy(wc_busy), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] init_byte(int i);
    return 8'((i * 37 + 11) & 8'hFF);
  endfunction

  function automatic logic [AW-1:0] pg_addr(logic [AW-1:0] a, int i);
    return {a[AW-1:4], 4'(a[3:0] + 4'(i))};
  endfunction

  // environment: array, page buffer, busy timer
  logic [7:0] mem [MEM_N];
  logic [7:0] pb_d [MEM_N];
  logic       pb_v [MEM_N];
  int busy_cnt;
  int commits = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_N; i++) begin
        mem[i] <= init_byte(i); pb_v[i] <= 1'b0; pb_d[i] <= 8'h00;
      end
      busy_cnt <= 0; wc_busy <= 1'b0; rd_data <= 8'h00;
    end else begin
      if (rd_en) rd_data <= mem[rd_addr];
      if (wr_valid && wr_ready) begin
        pb_v[wr_addr] <= 1'b1; pb_d[wr_addr] <= wr_data;
      end
      if (commit) begin
        commits <= commits + 1; busy_cnt <= BUSY_CYC; wc_busy <= 1'b1;
      end else if (busy_cnt == 1) begin
        for (int i = 0; i < MEM_N; i++)
          if (pb_v[i]) begin mem[i] <= pb_d[i]; pb_v[i] <= 1'b0; end
        busy_cnt <= 0; wc_busy <= 1'b0;
      end else if (busy_cnt != 0) begin
        busy_cnt <= busy_cnt - 1;
      end
    end
  end

  always @(posedge clk) wr_ready <= (($urandom % 4) != 0);

  // monitors for R12 and R13
  int viol12 = 0, viol13 = 0, scl_hi = 0;
  logic prev_oe = 1'b0, prev_stall = 1'b0;
  logic [AW-1:0] prev_wa = '0;
  logic [7:0] prev_wd = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_hi > 4 && sda_oe != prev_oe) viol12++;
      if (prev_stall && (!wr_valid || wr_addr != prev_wa || wr_data != prev_wd)) viol13++;
    end
    scl_hi     = scl_m ? scl_hi + 1 : 0;
    prev_oe    = sda_oe;
    prev_stall = wr_valid && !wr_ready;
    prev_wa    = wr_addr;
    prev_wd    = wr_data;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_mem [MEM_N];
  logic [AW-1:0] exp_ptr = '0;
  logic [7:0] tx_buf [32];

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(logic b);
    sda_m = b; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0; tick(2);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H/2); b = sda_line;
    tick(H/2); scl_m = 1'b0; tick(2);
  endtask

  task automatic start_c();
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(2*H);
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(x);
    ack = !x;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit m_ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin bit_in(x); d[i] = x; end
    bit_out(!m_ack);
  endtask

  function automatic logic [7:0] ctrl(logic [AW-1:0] a, logic b2, logic rw);
    return {4'b1010, b2, a[9:8], rw};
  endfunction

  task automatic poll_wait(output int polls);
    bit ack;
    polls = 0;
    do begin
      start_c(); send_byte(ctrl('0, 1'b0, 1'b0), ack); stop_c(); polls++;
    end while (!ack && polls < 60);
  endtask

  task automatic page_write(logic [AW-1:0] a, int n, logic b2, string tag);
    bit ack; int polls;
    start_c();
    send_byte(ctrl(a, b2, 1'b0), ack); chk(ack, {tag, " R3 ctrl ack"}, ack, 1);
    send_byte(a[7:0], ack);            chk(ack, {tag, " R3 addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(tx_buf[i], ack);       chk(ack, {tag, " R4 data ack"}, ack, 1);
      exp_mem[pg_addr(a, i)] = tx_buf[i];
    end
    stop_c();
    exp_ptr = pg_addr(a, n);
    poll_wait(polls);
    chk(polls > 1 && polls < 60, {tag, " R6 polling saw busy then ack"}, polls, 2);
  endtask

  task automatic rand_read(logic [AW-1:0] a, int n, string tag);
    bit ack; logic [7:0] d;
    start_c();
    send_byte(ctrl(a, 1'b0, 1'b0), ack); chk(ack, {tag, " R8 header ack"}, ack, 1);
    send_byte(a[7:0], ack);
    start_c();
    send_byte(ctrl(AW'($urandom), 1'b0, 1'b1), ack); chk(ack, {tag, " R8 read ctrl ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i != n - 1);
      chk(d == exp_mem[AW'(a + AW'(i))], {tag, " R8/R9 read data"}, d, exp_mem[AW'(a + AW'(i))]);
    end
    stop_c();
    exp_ptr = AW'(a + AW'(n));
  endtask

  task automatic cur_read(int n, string tag);
    bit ack; logic [7:0] d;
    start_c();
    send_byte(ctrl(AW'($urandom), 1'b1, 1'b1), ack); chk(ack, {tag, " R7 ctrl ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i != n - 1);
      chk(d == exp_mem[exp_ptr], {tag, " R7 current read"}, d, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + AW'(1);
    end
    stop_c();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ack; int c0, polls; logic [7:0] d; logic x; int ones;
    void'($urandom(32'd2024));
    for (int i = 0; i < MEM_N; i++) exp_mem[i] = init_byte(i);
    tick(5); rst_n = 1'b1; tick(5);
    // R1 reset state
    chk(!sda_oe && !wr_valid && !commit && !rd_en, "R1 reset outputs",
        {sda_oe, wr_valid, commit, rd_en}, 0);

    // R2 wrong device code is ignored
    c0 = commits;
    start_c(); send_byte(8'hB0, ack); chk(!ack, "R2 bad code nack", ack, 0);
    send_byte(8'h12, ack); chk(!ack, "R2 silent after bad code", ack, 0);
    send_byte(8'h34, ack); stop_c(); tick(4);
    chk(commits == c0, "R2 no commit for ignored write", commits, c0);

    // byte write, commit, busy polling
    c0 = commits;
    start_c(); send_byte(ctrl(10'h123, 1'b0, 1'b0), ack);
    send_byte(8'h23, ack); send_byte(8'h5A, ack); chk(ack, "R4 byte write ack", ack, 1);
    stop_c(); tick(2);
    exp_mem[10'h123] = 8'h5A; exp_ptr = 10'h124;
    chk(commits == c0 + 1, "R5 commit after write stop", commits, c0 + 1);
    start_c(); send_byte(ctrl('0, 1'b0, 1'b0), ack); stop_c();
    chk(!ack, "R6 nack own address while busy", ack, 0);
    poll_wait(polls);
    chk(polls < 60, "R6 ack returns after write cycle", polls, 1);

    // R8 random read, R7 current address read
    rand_read(10'h123, 1, "rr1");
    cur_read(2, "cur1");
    chk(commits == c0 + 1, "R5 no commit after reads", commits, c0 + 1);

    // R4 page wrap: 18 bytes starting near page end
    for (int i = 0; i < 18; i++) tx_buf[i] = 8'($urandom);
    page_write(10'h2F8, 18, 1'b0, "pgwrap");
    rand_read(10'h2F0, 16, "pgwrap R4 readback");
    page_write(10'h2F8, 1, 1'b0, "ptr");
    cur_read(1, "R7 after write");

    // R9 sequential wrap at top and across banks
    rand_read(10'h3FC, 8, "R9 top wrap");
    rand_read(10'h0FE, 4, "R9 bank cross");

    // R3 control bit 3 ignored
    tx_buf[0] = 8'hC3; tx_buf[1] = 8'h3C;
    page_write(10'h1C0, 2, 1'b1, "R3 b2");
    rand_read(10'h1C0, 2, "R3 b2 readback");

    // R11 START mid-byte aborts, no write, pointer from header
    c0 = commits;
    start_c(); send_byte(ctrl(10'h040, 1'b0, 1'b0), ack); send_byte(8'h40, ack);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    start_c(); send_byte(ctrl('0, 1'b0, 1'b1), ack); chk(ack, "R11 read after abort ack", ack, 1);
    recv_byte(d, 1'b0);
    chk(d == exp_mem[10'h040], "R11 data at header address", d, exp_mem[10'h040]);
    // R10 slave silent after master NACK
    ones = 0;
    for (int i = 0; i < 9; i++) begin bit_in(x); ones += int'(x); end
    chk(ones == 9, "R10 released after nack", ones, 9);
    stop_c(); tick(4);
    chk(commits == c0, "R11 no commit after abort", commits, c0);
    exp_ptr = 10'h041;

    // constrained random writes and reads
    for (int it = 0; it < 8; it++) begin
      logic [AW-1:0] a; int n;
      a = AW'($urandom); n = 1 + int'($urandom % 12);
      for (int i = 0; i < n; i++) tx_buf[i] = 8'($urandom);
      page_write(a, n, 1'($urandom), "rand R4");
      if (it % 2 == 0) cur_read(2, "rand R7");
      rand_read(a, n, "rand R8");
    end

    chk(viol12 == 0, "R12 sda change during scl high", viol12, 0);
    chk(viol13 == 0, "R13 write port hold", viol13, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule